// File: doc/BRIEF.md
# DS3 Transmit Frame Timing Generator

This block derives all terminal-side timing for a DS3 transmitter from one 44.736 MHz transmit clock. A position counter walks the 4760-bit M-frame, which is built from 56 blocks of 85 bits (7 subframes of 8 blocks). The first bit of every block carries overhead. A payload source watches the outputs to learn when it may present data: an active-low gap strobe covers each overhead bit, a frame reference pulse marks bit 1 of the frame, and in nibble mode a divide-by-four nibble clock plus an active-low nibble framing pulse pace a 4-bit source.

The nibble clock advances only on payload bits, so the 4704 payload bits of a frame come out as exactly 1176 nibbles. In serial mode the nibble outputs stay idle and an external framing input may realign the counter: a pulse declares the current bit to be bit 1 of the frame. In nibble mode that input has no effect.

Top module: `ds3_tx_timing`

## Requirements
- R1: While rst_n is low, gap_n and nib_frame_n are 1 and frame_ref and nib_clk are 0. In the first cycle after release the counter is at frame bit 1, so frame_ref is 1 and gap_n is 0.
- R2: gap_n is 0 for exactly one cycle at each block start, which is bit offset 0, 85, 170 and so on from frame bit 1. It is 1 at every other offset, so a frame holds 56 gap cycles.
- R3: frame_ref is 1 for one cycle in every 4760, at frame bit 1. That cycle is also a gap cycle.
- R4: In nibble mode, nib_clk is 1 at block offset 0. At a payload offset p from 1 to 84, nib_clk is 1 when (p-1) mod 4 is 0 or 1, and 0 otherwise.
- R5: In nibble mode, nib_frame_n is 0 exactly at frame offsets 5 to 8, which is the second nibble, and 1 elsewhere.
- R6: In serial mode (nibble_mode=0), nib_clk is 0 and nib_frame_n is 1.
- R7: In serial mode, a 1 on frame_in makes the current cycle frame bit 1. The next cycle is offset 1 and the next frame_ref follows 4760 cycles after the pulse. A pulse that lands on bit 1 leaves the timing unchanged.
- R8: In nibble mode, frame_in is ignored and frame_ref keeps its 4760-cycle spacing.
- R9: In nibble mode, nib_clk has 1176 rising transitions per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 44.736 MHz transmit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nibble_mode | input | 1 | 1 selects nibble timing, 0 selects serial timing |
| frame_in | input | 1 | Serial framing input: 1 marks the current bit as frame bit 1 |
| gap_n | output | 1 | Active-low strobe during overhead bits |
| frame_ref | output | 1 | One-cycle pulse at frame bit 1 |
| nib_clk | output | 1 | Nibble clock, the transmit clock divided by 4 over payload bits |
| nib_frame_n | output | 1 | Active-low nibble framing pulse during the second nibble |

## Verification
Every output is decoded without a register from the position state, so a result belongs to the same cycle as the counter position it describes. The bench samples on the falling edge, midway between updates. A frame_in pulse changes the state at the next rising edge, so its effect is checked one sample later, at offset 1, and again at the offsets and frame boundary that follow. Reset gating acts on the outputs without a clock, so the reset values are checked a short delay after rst_n falls.

// File: rtl/ds3_tx_timing.sv
module ds3_tx_timing #(
  parameter int BLK_BITS = 85,
  parameter int BLKS     = 56,
  parameter int NIB_BITS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nibble_mode,
  input  logic frame_in,
  output logic gap_n,
  output logic frame_ref,
  output logic nib_clk,
  output logic nib_frame_n
);

  localparam int BB_W = $clog2(BLK_BITS);
  localparam int BK_W = $clog2(BLKS);
  localparam int PH_W = $clog2(NIB_BITS);
  localparam int NIBS = BLKS * (BLK_BITS - 1) / NIB_BITS;
  localparam int NB_W = $clog2(NIBS);

  logic [BB_W-1:0] bbit;
  logic [BK_W-1:0] blk;
  logic [PH_W-1:0] ph;
  logic [NB_W-1:0] nib;

  wire ovh     = (bbit == '0);
  wire blk_end = (bbit == BB_W'(BLK_BITS - 1));
  wire frm_end = blk_end && (blk == BK_W'(BLKS - 1));
  wire ph_end  = (ph == PH_W'(NIB_BITS - 1));
  wire realign = frame_in && !nibble_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bbit <= '0;
      blk  <= '0;
      ph   <= '0;
      nib  <= '0;
    end else if (realign) begin
      bbit <= BB_W'(1);
      blk  <= '0;
      ph   <= '0;
      nib  <= '0;
    end else if (frm_end) begin
      bbit <= '0;
      blk  <= '0;
      ph   <= '0;
      nib  <= '0;
    end else begin
      bbit <= blk_end ? '0 : bbit + 1'b1;
      if (blk_end) blk <= blk + 1'b1;
      if (!ovh) begin
        ph <= ph_end ? '0 : ph + 1'b1;
        if (ph_end) nib <= nib + 1'b1;
      end
    end
  end

  assign gap_n       = !(rst_n && ovh);
  assign frame_ref   = rst_n && ovh && (blk == '0);
  assign nib_clk     = rst_n && nibble_mode && (ph < PH_W'(NIB_BITS / 2));
  assign nib_frame_n = !(rst_n && nibble_mode && (nib == NB_W'(1)));

  AST_GAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gap_n |=> gap_n); // R2
  AST_REF_ON_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ref |-> !gap_n); // R3
  AST_SERIAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !nibble_mode |-> (!nib_clk && nib_frame_n)); // R6
  AST_REALIGN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_in && !nibble_mode) |=> (gap_n && !frame_ref)); // R7
  AST_NFR_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nib_frame_n) |-> (nib_clk && gap_n)); // R5

endmodule

// File: tb/ds3_tx_timing_test.sv
module ds3_tx_timing_test;
  localparam int CLK_P = 10;
  localparam int FRM   = 4760;
  localparam int NV    = 14;
  localparam logic [16:0] VEC [NV] = '{
    {13'd0,    4'b0111}, {13'd1,    4'b1110}, {13'd2,    4'b1110},
    {13'd3,    4'b1010}, {13'd4,    4'b1010}, {13'd5,    4'b1100},
    {13'd6,    4'b1100}, {13'd7,    4'b1000}, {13'd8,    4'b1000},
    {13'd9,    4'b1110}, {13'd84,   4'b1010}, {13'd85,   4'b0110},
    {13'd86,   4'b1110}, {13'd4759, 4'b1010}
  };

  logic clk = 0, rst_n = 0, nibble_mode = 1, frame_in = 0;
  logic gap_n, frame_ref, nib_clk, nib_frame_n;
  int errors = 0, checks = 0, p = 0;

  ds3_tx_timing uut (.clk(clk), .rst_n(rst_n), .nibble_mode(nibble_mode),
    .frame_in(frame_in), .gap_n(gap_n), .frame_ref(frame_ref),
    .nib_clk(nib_clk), .nib_frame_n(nib_frame_n));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (offset %0d)", tag, act, exp, p);
    end
  endtask

  task automatic adv(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      p = (p + 1) % FRM;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int gaps, refs, rises, qbad;
    logic prev;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 gap_n in reset", gap_n, 1);
    chk("R1 frame_ref in reset", frame_ref, 0);
    chk("R1 nib_clk in reset", nib_clk, 0);
    chk("R1 nib_frame_n in reset", nib_frame_n, 1);
    @(negedge clk); rst_n = 1; #1; p = 0;
    chk("R1 frame_ref after release", frame_ref, 1);
    chk("R1 gap_n after release", gap_n, 0);

    gaps = 0; refs = 0; rises = 0; prev = 0;
    for (int c = 0; c < FRM; c++) begin
      for (int k = 0; k < NV; k++)
        if (int'(VEC[k][16:4]) == p) begin
          chk("R2 gap_n", gap_n, VEC[k][3]);
          chk("R4 nib_clk", nib_clk, VEC[k][2]);
          chk("R5 nib_frame_n", nib_frame_n, VEC[k][1]);
          chk("R3 frame_ref", frame_ref, VEC[k][0]);
        end
      if (!gap_n) gaps++;
      if (frame_ref) refs++;
      if (nib_clk && !prev) rises++;
      prev = nib_clk;
      adv(1);
    end
    chk("R2 gaps per frame", gaps, 56);
    chk("R3 refs per frame", refs, 1);
    chk("R9 nibble clock rises per frame", rises, 1176);
    chk("R3 frame_ref at next frame", frame_ref, 1);

    adv(100);
    frame_in = 1; adv(1); frame_in = 0;
    chk("R8 gap_n after ignored pulse", gap_n, 1);
    adv(FRM - 101);
    chk("R8 frame_ref spacing kept", frame_ref, 1);

    nibble_mode = 0;
    qbad = 0;
    for (int i = 0; i < 20; i++) begin
      adv(1);
      if (nib_clk || !nib_frame_n) qbad++;
    end
    chk("R6 nibble outputs idle in serial", qbad, 0);

    frame_in = 1; p = 0; adv(1); frame_in = 0;
    chk("R7 gap_n at offset 1", gap_n, 1);
    chk("R7 frame_ref at offset 1", frame_ref, 0);
    adv(84);
    chk("R7 gap at offset 85", gap_n, 0);
    adv(FRM - 86);
    chk("R7 no frame_ref before boundary", frame_ref, 0);
    adv(1);
    chk("R7 frame_ref after realign", frame_ref, 1);

    frame_in = 1; adv(1); frame_in = 0;
    chk("R7 matching pulse offset 1", gap_n, 1);
    adv(FRM - 1);
    chk("R7 matching pulse keeps frame", frame_ref, 1);

    nibble_mode = 1;
    adv(50);
    rst_n = 0; #1;
    chk("R1 gap_n mid-run reset", gap_n, 1);
    chk("R1 frame_ref mid-run reset", frame_ref, 0);
    chk("R1 nib_clk mid-run reset", nib_clk, 0);
    chk("R1 nib_frame_n mid-run reset", nib_frame_n, 1);
    @(negedge clk); rst_n = 1; #1; p = 0;
    chk("R1 frame_ref after second release", frame_ref, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule